// File: doc/BRIEF.md
# Multiplexed external bus controller

This block runs external memory cycles over a shared 16-bit address/data bus. A core-side client places an instruction fetch, a data read or a data write on a request port and holds it until the block returns a single-cycle acknowledge. Every bus cycle has four phases of one clock each. In the first phase the block drives the address. The second phase is a hold or turnaround phase. In the third phase the read or write strobe is low. The fourth phase is recovery.

Two outputs can each be set to one of two meanings. The address strobe can be a short latch-enable pulse or a level that marks the cycle as valid. The high-byte strobe can be a high-lane byte enable or a write strobe for odd bytes. The width of each cycle is 8 or 16 bits. A static configuration bit sets it, unless two enable bits hand the choice to an external width pin that is sampled when the request is taken. A 16-bit access on an 8-bit cycle is split into two byte cycles, and only one acknowledge is returned for the pair.

Top module: `muxBusCtrl`

## Requirements
- R1: A request seen in idle starts an address phase on the next clock, which is followed by hold, data and recovery phases of one clock each. In the address phase `adOe` is 1 and `adOut` carries the cycle address. `reqAck` is high for exactly the recovery phase of the last cycle of the access.
- R2: With `cfgValidMode`=0, `addrStrobe` is high only in the address phase and low at all other times, idle included. It therefore falls at the end of the address phase.
- R3: With `cfgValidMode`=1, `addrStrobe` is high in idle and in the address phase. It is low through the hold, data and recovery phases, so it also falls at the end of the address phase and rises again once the cycle ends.
- R4: `rdN` is low only in the data phase of a fetch or read (`reqKind` 0 or 1). `wrN` is low only in the data phase of a write (`reqKind` 2). The two are never low together, and `adOe` is 0 while `rdN` is low.
- R5: With `cfgWrHighMode`=0, `hiStrobeN` is low from the address phase through the data phase of a 16-bit write cycle that carries a word or an odd-address byte. In every other case it stays high.
- R6: With `cfgWrHighMode`=1, `hiStrobeN` is low only in the data phase of a write that writes an odd byte. On a 16-bit cycle that means a word or an odd-address byte. On an 8-bit cycle it means an odd cycle address.
- R7: When `cfgDynA` and `cfgDynB` are both 1, the cycle width comes from `widthPin` at acceptance (0 gives 8 bits, 1 gives 16 bits). Otherwise `cfgWide16` sets the width.
- R8: A word access (`reqWord`=1) uses the address with bit 0 cleared. On an 8-bit cycle it runs two cycles, the even address first and then address+1, and `reqAck` is given only in the recovery phase of the second cycle.
- R9: In the hold and data phases of a write, `adOe` is 1. `adOut` carries the full word for a word on a 16-bit cycle. Otherwise it carries the byte of the current cycle on both lanes: the low write byte, or the high write byte for the second half of a split.
- R10: While `reqAck` is high, `rspData` holds the read result. A word on a 16-bit cycle gives the full `adIn` word. A byte on a 16-bit cycle gives lane `adIn[15:8]` for an odd address and `adIn[7:0]` otherwise. A byte on an 8-bit cycle gives `adIn[7:0]`. A split gives `{second low lane, first low lane}`. Bytes are zero-extended.
- R11: `instFetch` is high through all four phases of every cycle of a fetch, and low otherwise.
- R12: After reset the block is idle with `rdN`, `wrN` and `hiStrobeN` high, and with `adOe`, `reqAck` and `instFetch` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present, held until acknowledge |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write |
| reqWord | input | 1 | 1 for a 16-bit access, 0 for a byte |
| reqAddr | input | 16 | Byte address of the access |
| reqWdata | input | 16 | Write data (byte accesses use bits 7:0) |
| reqAck | output | 1 | One-clock acknowledge in the final recovery phase |
| rspData | output | 16 | Read result, valid with acknowledge |
| cfgValidMode | input | 1 | 0 latch pulse, 1 address-valid level |
| cfgWrHighMode | input | 1 | 0 high-lane byte enable, 1 odd-byte write strobe |
| cfgDynA | input | 1 | Dynamic width enable, first bit |
| cfgDynB | input | 1 | Dynamic width enable, second bit |
| cfgWide16 | input | 1 | Static width: 1 for 16-bit cycles |
| widthPin | input | 1 | External width select: 1 for 16-bit |
| adIn | input | 16 | Bus value seen on the shared lines |
| adOut | output | 16 | Value driven on the shared lines |
| adOe | output | 1 | Drive enable for the shared lines |
| addrStrobe | output | 1 | Address strobe for the external latch |
| hiStrobeN | output | 1 | High-byte strobe, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| instFetch | output | 1 | High during external fetch cycles |

## Verification
On every cycle the assertions check that the read and write strobes never overlap and that the bus is released while a read strobe is low. They also check that the pulse-mode strobe lasts one clock and comes with a driven address, that the high-byte strobe only appears while write data or an address is on the bus, that an acknowledge lasts one clock right after a data phase, and that a fetch never writes. Only the bench scenarios can show the rest. That covers the exact phase in which each pin changes in both strobe modes, whether the width comes from the pin or from the static bit, the two-cycle split of a word with its even-then-odd addresses, where write bytes land on the lanes, and how read results are assembled.

// File: rtl/muxBusCtrlPkg.sv
package muxBusCtrlPkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_HOLD,
    PH_DATA,
    PH_RECOV
  } phase_t;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;
    logic driveAddr;
    logic driveData;
    logic capture;
    logic secondHalf;
    logic cycleWide;
    logic accessWord;
  } busCtl_t;

endpackage

// File: rtl/muxBusCtrlSeq.sv
module muxBusCtrlSeq
  import muxBusCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqWord,
  input  logic       cfgValidMode,
  input  logic       cfgWrHighMode,
  input  logic       cfgDynA,
  input  logic       cfgDynB,
  input  logic       cfgWide16,
  input  logic       widthPin,
  input  logic       addrOdd,
  output busCtl_t    ctl,
  output logic       addrStrobe,
  output logic       hiStrobeN,
  output logic       rdN,
  output logic       wrN,
  output logic       instFetch,
  output logic       reqAck
);

  phase_t     phase;
  logic [1:0] kind;
  logic       word;
  logic       wide;
  logic       second;

  logic sampleWide;
  logic isWrite;
  logic lastHalf;
  logic inAddr, inHold, inData, inRecov;
  logic oddByteWrite;
  logic hiLaneWrite;

  assign sampleWide = (cfgDynA && cfgDynB) ? widthPin : cfgWide16;
  assign isWrite    = (kind == KIND_WRITE);
  assign lastHalf   = !(word && !wide) || second;

  assign inAddr  = (phase == PH_ADDR);
  assign inHold  = (phase == PH_HOLD);
  assign inData  = (phase == PH_DATA);
  assign inRecov = (phase == PH_RECOV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      kind   <= KIND_FETCH;
      word   <= 1'b0;
      wide   <= 1'b0;
      second <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            kind   <= reqKind;
            word   <= reqWord;
            wide   <= sampleWide;
            second <= 1'b0;
            phase  <= PH_ADDR;
          end
        end
        PH_ADDR:  phase <= PH_HOLD;
        PH_HOLD:  phase <= PH_DATA;
        PH_DATA:  phase <= PH_RECOV;
        PH_RECOV: begin
          if (lastHalf) begin
            phase <= PH_IDLE;
          end else begin
            second <= 1'b1;
            phase  <= PH_ADDR;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadReq    = (phase == PH_IDLE) && reqValid;
    ctl.driveAddr  = inAddr;
    ctl.driveData  = isWrite && (inHold || inData);
    ctl.capture    = !isWrite && inData;
    ctl.secondHalf = second;
    ctl.cycleWide  = wide;
    ctl.accessWord = word;
  end

  // odd byte written: on a wide cycle any word or odd byte, on a narrow one the cycle address
  assign oddByteWrite = wide ? (word || addrOdd) : addrOdd;
  assign hiLaneWrite  = wide && (word || addrOdd);

  always_comb begin
    if (cfgValidMode) addrStrobe = !(inHold || inData || inRecov);
    else              addrStrobe = inAddr;
    rdN = !(inData && !isWrite);
    wrN = !(inData && isWrite);
    if (cfgWrHighMode) hiStrobeN = !(isWrite && inData && oddByteWrite);
    else               hiStrobeN = !(isWrite && (inAddr || inHold || inData) && hiLaneWrite);
    instFetch = (phase != PH_IDLE) && (kind == KIND_FETCH);
    reqAck    = inRecov && lastHalf;
  end

endmodule

// File: rtl/muxBusCtrlPath.sv
module muxBusCtrlPath
  import muxBusCtrlPkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  busCtl_t          ctl,
  input  logic             reqWord,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  output logic [BUS_W-1:0] rspData,
  output logic             addrOdd
);

  localparam int LANE_W = BUS_W / 2;

  logic [BUS_W-1:0]  baseAddr;
  logic [BUS_W-1:0]  wdata;
  logic [BUS_W-1:0]  rdata;
  logic [BUS_W-1:0]  cycleAddr;
  logic [LANE_W-1:0] writeByte;
  logic [BUS_W-1:0]  writeBus;
  logic [LANE_W-1:0] inLane;
  logic              fullWord;

  assign fullWord  = ctl.cycleWide && ctl.accessWord;
  assign cycleAddr = baseAddr + BUS_W'(ctl.secondHalf);
  assign addrOdd   = cycleAddr[0];

  assign writeByte = ctl.secondHalf ? wdata[BUS_W-1:LANE_W] : wdata[LANE_W-1:0];
  assign writeBus  = fullWord ? wdata : {writeByte, writeByte};
  assign inLane    = (ctl.cycleWide && addrOdd) ? adIn[BUS_W-1:LANE_W] : adIn[LANE_W-1:0];

  always_comb begin
    if (ctl.driveAddr)      adOut = cycleAddr;
    else if (ctl.driveData) adOut = writeBus;
    else                    adOut = '0;
  end

  assign adOe    = ctl.driveAddr || ctl.driveData;
  assign rspData = rdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      wdata    <= '0;
      rdata    <= '0;
    end else if (ctl.loadReq) begin
      baseAddr <= reqWord ? {reqAddr[BUS_W-1:1], 1'b0} : reqAddr;
      wdata    <= reqWdata;
      rdata    <= '0;
    end else if (ctl.capture) begin
      if (fullWord)            rdata <= adIn;
      else if (ctl.secondHalf) rdata[BUS_W-1:LANE_W] <= inLane;
      else                     rdata <= {{LANE_W{1'b0}}, inLane};
    end
  end

endmodule

// File: rtl/muxBusCtrl.sv
module muxBusCtrl
  import muxBusCtrlPkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqWord,
  input  logic [BUS_W-1:0] reqAddr,
  input  logic [BUS_W-1:0] reqWdata,
  output logic             reqAck,
  output logic [BUS_W-1:0] rspData,
  input  logic             cfgValidMode,
  input  logic             cfgWrHighMode,
  input  logic             cfgDynA,
  input  logic             cfgDynB,
  input  logic             cfgWide16,
  input  logic             widthPin,
  input  logic [BUS_W-1:0] adIn,
  output logic [BUS_W-1:0] adOut,
  output logic             adOe,
  output logic             addrStrobe,
  output logic             hiStrobeN,
  output logic             rdN,
  output logic             wrN,
  output logic             instFetch
);

  busCtl_t ctl;
  logic    addrOdd;

  muxBusCtrlSeq u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqKind      (reqKind),
    .reqWord      (reqWord),
    .cfgValidMode (cfgValidMode),
    .cfgWrHighMode(cfgWrHighMode),
    .cfgDynA      (cfgDynA),
    .cfgDynB      (cfgDynB),
    .cfgWide16    (cfgWide16),
    .widthPin     (widthPin),
    .addrOdd      (addrOdd),
    .ctl          (ctl),
    .addrStrobe   (addrStrobe),
    .hiStrobeN    (hiStrobeN),
    .rdN          (rdN),
    .wrN          (wrN),
    .instFetch    (instFetch),
    .reqAck       (reqAck)
  );

  muxBusCtrlPath #(.BUS_W(BUS_W)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqWord (reqWord),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .adIn    (adIn),
    .adOut   (adOut),
    .adOe    (adOe),
    .rspData (rspData),
    .addrOdd (addrOdd)
  );

endmodule

// File: rtl/muxBusCtrlChk.sv
module muxBusCtrlChk (
  input logic clk,
  input logic rstN,
  input logic cfgValidMode,
  input logic reqAck,
  input logic adOe,
  input logic addrStrobe,
  input logic hiStrobeN,
  input logic rdN,
  input logic wrN,
  input logic instFetch
);

  a_r4_no_dual_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  a_r4_read_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  a_r2_pulse_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgValidMode && addrStrobe) |=> !addrStrobe);

  a_r2_pulse_with_address: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgValidMode && addrStrobe) |-> adOe);

  a_r5_hi_strobe_driven_bus: assert property (@(posedge clk) disable iff (!rstN)
    !hiStrobeN |-> adOe);

  a_r1_ack_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  a_r1_ack_after_data: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> $past(!rdN || !wrN));

  a_r11_fetch_never_writes: assert property (@(posedge clk) disable iff (!rstN)
    instFetch |-> wrN);

endmodule

bind muxBusCtrl muxBusCtrlChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgValidMode(cfgValidMode),
  .reqAck      (reqAck),
  .adOe        (adOe),
  .addrStrobe  (addrStrobe),
  .hiStrobeN   (hiStrobeN),
  .rdN         (rdN),
  .wrN         (wrN),
  .instFetch   (instFetch)
);

// File: tb/muxBusCtrl_bench.sv
module muxBusCtrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             reqValid;
  logic [1:0]       reqKind;
  logic             reqWord;
  logic [BUS_W-1:0] reqAddr;
  logic [BUS_W-1:0] reqWdata;
  logic             reqAck;
  logic [BUS_W-1:0] rspData;
  logic             cfgValidMode, cfgWrHighMode, cfgDynA, cfgDynB, cfgWide16, widthPin;
  logic [BUS_W-1:0] adIn;
  logic [BUS_W-1:0] adOut;
  logic             adOe, addrStrobe, hiStrobeN, rdN, wrN, instFetch;

  int checks = 0;
  int errors = 0;

  muxBusCtrl #(.BUS_W(BUS_W)) u_muxBusCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspData(rspData),
    .cfgValidMode(cfgValidMode), .cfgWrHighMode(cfgWrHighMode), .cfgDynA(cfgDynA),
    .cfgDynB(cfgDynB), .cfgWide16(cfgWide16), .widthPin(widthPin), .adIn(adIn),
    .adOut(adOut), .adOe(adOe), .addrStrobe(addrStrobe), .hiStrobeN(hiStrobeN),
    .rdN(rdN), .wrN(wrN), .instFetch(instFetch)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] memVal(input logic [15:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + 8'h3C};
  endfunction

  task automatic runAccess(input logic [1:0] kind, input logic [15:0] addr,
                           input logic [15:0] wd, input logic word,
                           input logic vMode, input logic wrhMode, input logic dA,
                           input logic dB, input logic w16, input logic pin);
    logic        wide, isWr;
    logic [15:0] base, cycA, expBus, expRsp, m0, m1;
    logic [7:0]  b;
    int          n;
    logic        hiLane, oddWr;
    @(negedge clk);
    cfgValidMode = vMode; cfgWrHighMode = wrhMode; cfgDynA = dA; cfgDynB = dB;
    cfgWide16 = w16; widthPin = pin;
    reqKind = kind; reqAddr = addr; reqWdata = wd; reqWord = word; reqValid = 1'b1;
    wide = (dA && dB) ? pin : w16;                       // R7
    isWr = (kind == 2'd2);
    base = word ? {addr[15:1], 1'b0} : addr;             // R8
    n    = (word && !wide) ? 2 : 1;
    for (int k = 0; k < n; k++) begin
      cycA   = base + 16'(k);
      hiLane = isWr && wide && (word || cycA[0]);
      oddWr  = isWr && (wide ? (word || cycA[0]) : cycA[0]);
      b      = (word && k == 1) ? wd[15:8] : wd[7:0];
      expBus = (wide && word) ? wd : {b, b};
      // address phase
      @(negedge clk);
      reqValid = 1'b0;
      adIn = memVal(cycA);
      chk("R1 address phase adOe", 32'(adOe), 32'd1);
      chk("R1/R8 address phase adOut", 32'(adOut), 32'(cycA));
      chk(vMode ? "R3 strobe high in address phase" : "R2 pulse in address phase",
          32'(addrStrobe), 32'd1);
      chk("R11 instFetch address phase", 32'(instFetch), 32'(kind == 2'd0));
      chk(wrhMode ? "R6 hiStrobeN address phase" : "R5 hiStrobeN address phase",
          32'(hiStrobeN), wrhMode ? 32'd1 : 32'(!hiLane));
      // hold phase
      @(negedge clk);
      chk(vMode ? "R3 strobe low in hold" : "R2 strobe low in hold", 32'(addrStrobe), 32'd0);
      chk("R9 hold adOe", 32'(adOe), 32'(isWr));
      if (isWr) chk("R9 hold write data", 32'(adOut), 32'(expBus));
      // data phase
      @(negedge clk);
      chk("R4 rdN in data phase", 32'(rdN), 32'(isWr));
      chk("R4 wrN in data phase", 32'(wrN), 32'(!isWr));
      if (isWr) chk("R9 data phase write data", 32'(adOut), 32'(expBus));
      chk(wrhMode ? "R6 hiStrobeN data phase" : "R5 hiStrobeN data phase",
          32'(hiStrobeN), wrhMode ? 32'(!oddWr) : 32'(!hiLane));
      chk("R11 instFetch data phase", 32'(instFetch), 32'(kind == 2'd0));
      // recovery phase
      @(negedge clk);
      chk(vMode ? "R3 strobe low in recovery" : "R2 strobe low in recovery",
          32'(addrStrobe), 32'd0);
      chk("R1/R8 acknowledge timing", 32'(reqAck), 32'(k == n - 1));
      chk("R4 strobes idle in recovery", 32'({rdN, wrN, hiStrobeN}), 32'd7);
    end
    if (!isWr) begin
      m0 = memVal(base);
      m1 = memVal(base + 16'd1);
      if (wide && word)   expRsp = m0;
      else if (word)      expRsp = {m1[7:0], m0[7:0]};
      else if (wide)      expRsp = base[0] ? {8'h00, m0[15:8]} : {8'h00, m0[7:0]};
      else                expRsp = {8'h00, m0[7:0]};
      chk("R10 read result", 32'(rspData), 32'(expRsp));
    end
    @(negedge clk);
    chk(vMode ? "R3 strobe high after cycle" : "R2 strobe low in idle",
        32'(addrStrobe), 32'(vMode));
    chk("R11 instFetch idle", 32'(instFetch), 32'd0);
    chk("R1 idle bus released", 32'(adOe), 32'd0);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqWord = 1'b0;
    reqAddr = '0; reqWdata = '0; adIn = '0;
    cfgValidMode = 1'b0; cfgWrHighMode = 1'b0; cfgDynA = 1'b0; cfgDynB = 1'b0;
    cfgWide16 = 1'b1; widthPin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 reset rdN/wrN/hiStrobeN", 32'({rdN, wrN, hiStrobeN}), 32'd7);
    chk("R12 reset adOe", 32'(adOe), 32'd0);
    chk("R12 reset reqAck", 32'(reqAck), 32'd0);
    chk("R12 reset instFetch", 32'(instFetch), 32'd0);
    chk("R2 idle pulse strobe low", 32'(addrStrobe), 32'd0);
    cfgValidMode = 1'b1;
    @(negedge clk);
    chk("R3 idle valid strobe high", 32'(addrStrobe), 32'd1);

    // directed corners
    runAccess(2'd1, 16'h1235, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R8 split read
    runAccess(2'd2, 16'h4470, 16'hBEEF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R8 split write, R6
    runAccess(2'd1, 16'h2000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // R7 pin low
    runAccess(2'd0, 16'h3002, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1); // R7 pin high
    runAccess(2'd1, 16'h5554, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R7 one bit only
    runAccess(2'd2, 16'h0101, 16'h00C7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R5 odd byte
    runAccess(2'd2, 16'h0100, 16'h0093, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R5 even byte
    runAccess(2'd2, 16'h0101, 16'h0011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R6 odd byte
    runAccess(2'd2, 16'h0203, 16'h0022, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R6 narrow odd
    runAccess(2'd1, 16'h7777, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // R10 odd lane

    // constrained random
    void'($urandom(32'd2024));
    for (int i = 0; i < 60; i++) begin
      runAccess(2'($urandom % 3), 16'($urandom), 16'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule